// File: doc/BRIEF.md
# Multichannel Window Alarm Monitor

This block watches a stream of 12-bit conversion results, each tagged with a 2-bit channel number and qualified by a valid strobe. Each of the four channels has its own upper and lower 8-bit limit. A result whose top eight bits reach or pass either limit counts as a trip for that channel. Each channel has its own trip counter. When a channel's counter reaches a shared 3-bit alarm-count setting, a sticky alarm flag is set for that channel.

The alarm flags drive an interrupt output through a per-channel enable mask. Software reads the flags from a status location. That read also clears every flag and every trip counter. All settings sit behind a simple synchronous read/write register port with one cycle of read latency.

Register map (4-bit address): 0..3 upper limit of channels 0..3; 4..7 lower limit of channels 0..3; 8 alarm-count setting in bits [2:0]; 9 interrupt enable mask in bits [3:0], bit i for channel i; 10 status and clear, bits [3:0] alarm flags, bit i for channel i. Addresses 11..15 are unmapped.

Top module: `win_alarm_mon`

## Requirements
- R1: Limit, alarm-count and mask registers accept writes on the register port (reg_we). A read (reg_re) presents the addressed value on reg_rdata one clock after the read is sampled, and reg_rdata holds it until the next read.
- R2: A valid result for channel c is a trip when its bits [11:4] are less than or equal to channel c's lower limit, or greater than or equal to its upper limit. Results strictly inside the window are not trips.
- R3: A trip advances only the counter of the channel in res_chan. The counters and alarm flags of the other channels are unaffected.
- R4: With alarm-count setting N (address 8, bits [2:0]), a channel's alarm flag is set by the trip that brings its counter to N. A setting of 0 behaves as 1. The counter saturates at N and never wraps.
- R5: Alarm flags are sticky until cleared. A read of address 10 returns the flags in bits [3:0], with bit i for channel i, and zeros in bits [7:4].
- R6: irq is high exactly when some channel i has its alarm flag set and mask bit i (address 9, bit i) set. Changing the mask updates irq even while the flags stay unchanged.
- R7: A read of address 10 returns the flag values from before the clear. It then clears all alarm flags and all trip counters.
- R8: When a trip and a status read fall in the same cycle, the clear wins. That trip is discarded, and counting restarts from zero with the next trip.
- R9: After reset, the upper limits are 0xFF, the lower limits 0x00, the alarm-count setting 0, the mask 0, the flags and counters 0, irq is 0 and reg_rdata is 0.
- R10: Writes to address 10 and to unmapped addresses change nothing. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Result strobe |
| res_chan | input | 2 | Channel tag of the result |
| res_data | input | 12 | Conversion result |
| reg_we | input | 1 | Register write enable |
| reg_re | input | 1 | Register read enable |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, one cycle after reg_re |
| irq | output | 1 | Masked OR of the alarm flags |

## Verification
A trip and the clearing status read can fall in the same clock edge. The bench provokes this by raising res_valid with a violating result in the same cycle as a read of address 10. With a threshold of 2 and one trip already counted, the read must return 0. After that, one more trip must leave irq low and a second trip must raise it. A discarded trip gives this pattern; a trip that survived the clear, or a counter left uncleared, would raise irq one trip early.

// File: rtl/win_alarm_mon.sv
module win_alarm_mon #(
  parameter int NCH = 4,
  parameter int DW  = 12,
  parameter int LW  = 8,
  parameter int CW  = 3,
  parameter int AW  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   res_valid,
  input  logic [$clog2(NCH)-1:0] res_chan,
  input  logic [DW-1:0]          res_data,
  input  logic                   reg_we,
  input  logic                   reg_re,
  input  logic [AW-1:0]          reg_addr,
  input  logic [LW-1:0]          reg_wdata,
  output logic [LW-1:0]          reg_rdata,
  output logic                   irq
);
  localparam int SW       = $clog2(NCH);
  localparam int LOW_BITS = DW - LW;
  localparam int A_LO     = NCH;
  localparam int A_CFG    = 2 * NCH;
  localparam int A_MASK   = 2 * NCH + 1;
  localparam int A_STAT   = 2 * NCH + 2;

  logic [LW-1:0]  up_q [NCH];
  logic [LW-1:0]  lo_q [NCH];
  logic [CW-1:0]  thr_q;
  logic [NCH-1:0] mask_q;
  logic [CW-1:0]  cnt_q [NCH];
  logic           alm_q [NCH];
  logic [NCH-1:0] alm_vec;
  logic [LW-1:0]  rd_mux;
  logic [CW-1:0]  thr_eff;
  logic           clr;

  assign clr     = reg_re && (reg_addr == AW'(A_STAT));
  assign thr_eff = (thr_q == '0) ? CW'(1) : thr_q;
  assign irq     = |(alm_vec & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= '0;
      mask_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        up_q[i] <= '1;
        lo_q[i] <= '0;
      end
    end else if (reg_we) begin
      for (int i = 0; i < NCH; i++) begin
        if (reg_addr == AW'(i))        up_q[i] <= reg_wdata;
        if (reg_addr == AW'(A_LO + i)) lo_q[i] <= reg_wdata;
      end
      if (reg_addr == AW'(A_CFG))  thr_q  <= reg_wdata[CW-1:0];
      if (reg_addr == AW'(A_MASK)) mask_q <= reg_wdata[NCH-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCH; i++) begin
      if (reg_addr == AW'(i))        rd_mux = up_q[i];
      if (reg_addr == AW'(A_LO + i)) rd_mux = lo_q[i];
    end
    if (reg_addr == AW'(A_CFG))  rd_mux = LW'(thr_q);
    if (reg_addr == AW'(A_MASK)) rd_mux = LW'(mask_q);
    if (reg_addr == AW'(A_STAT)) rd_mux = LW'(alm_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic trip;
    logic below, above;
    logic [CW:0] cnt_inc;

    assign below   = res_data <= {lo_q[g], {LOW_BITS{1'b1}}};
    assign above   = res_data >= {up_q[g], {LOW_BITS{1'b0}}};
    assign trip    = res_valid && (res_chan == SW'(g)) && (below || above);
    assign cnt_inc = {1'b0, cnt_q[g]} + 1'b1;
    assign alm_vec[g] = alm_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[g] <= '0;
        alm_q[g] <= 1'b0;
      end else if (clr) begin
        cnt_q[g] <= '0;
        alm_q[g] <= 1'b0;
      end else if (trip) begin
        if (cnt_q[g] < thr_eff) cnt_q[g] <= cnt_inc[CW-1:0];
        if (cnt_inc >= {1'b0, thr_eff}) alm_q[g] <= 1'b1;
      end
    end

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_q[g] && !clr) |=> alm_q[g]);

    p_rise_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alm_q[g]) |-> $past(res_valid && (res_chan == SW'(g))));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q[g] == '0) && !alm_q[g]);

    p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt_q[g] >= $past(cnt_q[g])));
  end

  p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (alm_vec != '0));

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && res_valid) |=> (alm_vec == '0));
endmodule

// File: tb/win_alarm_mon_tb.sv
module win_alarm_mon_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       res_valid = 1'b0;
  logic [1:0] res_chan = '0;
  logic [11:0] res_data = '0;
  logic       reg_we = 1'b0;
  logic       reg_re = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  localparam logic [3:0] A_CFG = 4'd8, A_MASK = 4'd9, A_STAT = 4'd10;

  always #10 clk = ~clk;

  win_alarm_mon dut_i (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic conv(logic [1:0] c, logic [11:0] v);
    res_valid = 1'b1; res_chan = c; res_data = v;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R9 rdata", reg_rdata, 0);
    check("R9 irq", irq, 0);
    rd(4'd0, d); check("R9 upper0", d, 8'hFF);
    rd(4'd7, d); check("R9 lower3", d, 8'h00);
    rd(A_CFG, d); check("R9 count", d, 0);
    rd(A_MASK, d); check("R9 mask", d, 0);
    rd(A_STAT, d); check("R9 status", d, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(4'd2, 8'hA5); wr(4'd5, 8'h3C); wr(A_CFG, 8'hFE); wr(A_MASK, 8'h0B);
    rd(4'd2, d); check("R1 upper2", d, 8'hA5);
    rd(4'd5, d); check("R1 lower1", d, 8'h3C);
    rd(A_CFG, d); check("R1 count", d, 8'h06);
    rd(A_MASK, d); check("R1 mask", d, 8'h0B);
    @(negedge clk); check("R1 rdata holds", reg_rdata, 8'h0B);
  endtask

  task automatic t_window();
    logic [7:0] d;
    wr(A_CFG, 8'd1); wr(4'd0, 8'hC0); wr(4'd4, 8'h40);
    rd(A_STAT, d);
    conv(2'd0, 12'h40F); rd(A_STAT, d); check("R2 equal lower", d, 8'h01);
    conv(2'd0, 12'h410); rd(A_STAT, d); check("R2 just inside low", d, 8'h00);
    conv(2'd0, 12'hC00); rd(A_STAT, d); check("R2 equal upper", d, 8'h01);
    conv(2'd0, 12'hBFF); rd(A_STAT, d); check("R2 just inside high", d, 8'h00);
    conv(2'd0, 12'h000); rd(A_STAT, d); check("R2 far below", d, 8'h01);
  endtask

  task automatic t_count();
    logic [7:0] d;
    wr(A_CFG, 8'd3); wr(4'd1, 8'hF0); wr(4'd5, 8'h10); wr(A_MASK, 8'h0F);
    conv(2'd1, 12'h050); conv(2'd1, 12'hF80);
    check("R4 two of three", irq, 0);
    conv(2'd1, 12'h100);
    check("R4 third trip irq", irq, 1);
    rd(A_STAT, d); check("R4 status ch1", d, 8'h02);
    check("R7 irq after clear", irq, 0);
    wr(A_CFG, 8'd0);
    conv(2'd1, 12'hFFF); rd(A_STAT, d); check("R4 zero acts as one", d, 8'h02);
  endtask

  task automatic t_isolation();
    logic [7:0] d;
    wr(A_CFG, 8'd1);
    wr(4'd2, 8'h80); wr(4'd6, 8'h20); wr(4'd3, 8'hF0); wr(4'd7, 8'h01);
    conv(2'd2, 12'h900);
    conv(2'd3, 12'h500);
    rd(A_STAT, d); check("R3 only ch2", d, 8'h04);
  endtask

  task automatic t_saturate();
    logic [7:0] d;
    wr(A_CFG, 8'd7);
    for (int k = 0; k < 12; k++) conv(2'd0, 12'h000);
    check("R4 saturation keeps alarm", irq, 1);
    rd(A_STAT, d); check("R4 saturated status", d, 8'h01);
  endtask

  task automatic t_clear_counters();
    logic [7:0] d;
    wr(A_CFG, 8'd3);
    conv(2'd0, 12'h000); conv(2'd0, 12'h000);
    rd(A_STAT, d); check("R7 status before third", d, 8'h00);
    conv(2'd0, 12'h000);
    check("R7 counter reset", irq, 0);
    conv(2'd0, 12'h000); conv(2'd0, 12'h000);
    check("R7 recount to three", irq, 1);
    rd(A_STAT, d); check("R7 returns pre-clear", d, 8'h01);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    wr(A_CFG, 8'd2);
    conv(2'd0, 12'h000);
    res_valid = 1'b1; res_chan = 2'd0; res_data = 12'h000;
    reg_re = 1'b1; reg_addr = A_STAT;
    @(negedge clk);
    res_valid = 1'b0; reg_re = 1'b0;
    check("R8 read value", reg_rdata, 8'h00);
    check("R8 no alarm", irq, 0);
    conv(2'd0, 12'h000);
    check("R8 trip discarded", irq, 0);
    conv(2'd0, 12'h000);
    check("R8 count resumes", irq, 1);
    rd(A_STAT, d);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(A_CFG, 8'd1); wr(A_MASK, 8'h07);
    conv(2'd3, 12'h000);
    check("R6 masked channel", irq, 0);
    wr(A_MASK, 8'h08);
    check("R6 unmask", irq, 1);
    rd(A_STAT, d); check("R5 status bit3", d, 8'h08);
  endtask

  task automatic t_ignored();
    logic [7:0] d;
    wr(A_STAT, 8'hFF);
    check("R10 status write irq", irq, 0);
    rd(A_STAT, d); check("R10 status write", d, 8'h00);
    wr(4'd12, 8'h55);
    rd(4'd12, d); check("R10 unmapped read", d, 8'h00);
    rd(4'd2, d); check("R10 upper2 intact", d, 8'h80);
    rd(A_MASK, d); check("R10 mask intact", d, 8'h08);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_window();
    t_count();
    t_isolation();
    t_saturate();
    t_clear_counters();
    t_collision();
    t_mask();
    t_ignored();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule